// File: doc/BRIEF.md
# Unaligned Transfer Byte-Enable Splitter

This block connects an internal operand request to a 32-bit external bus. It takes an operand of one, two or four bytes, a direction and write data. The starting byte address may be any value. The external address carries only the dword index. The block never drives the two low address bits. Instead, it marks the byte lanes that hold part of the operand with active-low per-lane enables.

An operand that reaches past the end of a dword is split into two back-to-back bus cycles. The lower dword goes first. On writes, the block rotates each operand byte onto its lane. On reads, it collects the returned lanes from every cycle and shifts them back into operand order.

Each request is accepted only while the block is idle. A bus cycle ends when the ready input is sampled high. After the last cycle, the block raises a one-cycle done pulse together with the assembled read data.

Top module: `xfer_lane_splitter`

## Requirements
- R1: `bus_addr` equals bits 31..2 of the operand's first byte address during the first bus cycle of a request. There is no output for the two low address bits.
- R2: `req_size` selects the operand length: 0 is one byte, 1 is two bytes, 2 and 3 are four bytes. Any starting address is legal for every length.
- R3: Operand byte i travels on lane (start + i) mod 4, where lane L is data bits 8L+7..8L and enable bit L. An enable bit is 0 (active) in a cycle only when its lane carries an operand byte. Across all cycles of a request, every operand byte appears exactly once.
- R4: In every bus cycle the active enables form one contiguous, non-empty group of lanes.
- R5: A request whose bytes touch two dwords takes exactly two bus cycles, and any other request takes one. The second cycle's `bus_addr` is the first cycle's plus one, wrapping at the top of the address space.
- R6: `bus_addr`, `bus_be_n` and `bus_write` stay constant while a bus cycle waits for `bus_ready`.
- R7: During a write, `bus_write` is 1 and each enabled lane of `bus_wdata` holds its operand byte. During a read, `bus_write` is 0.
- R8: For a read, `done_rdata` holds operand byte i in bits 8i+7..8i, gathered from the lanes of the cycles. Bytes above the operand length are zero.
- R9: A request is accepted when `req_valid` is high and `req_busy` is low. `req_busy` is high from the cycle after acceptance until the done cycle. A `req_valid` seen while busy is ignored and causes no bus cycle.
- R10: `done` is high for exactly one cycle, the cycle after `bus_ready` ends the last bus cycle. `req_busy` is low in that cycle, so a new request can be accepted there.
- R11: A synchronous active-high `rst` returns the block to idle at the next edge, with `bus_be_n` all ones, `bus_active`, `req_busy` and `done` low. This holds even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the operand's first byte |
| req_size | input | 2 | Length code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| req_wdata | input | 32 | Write operand, byte 0 in bits 7..0 |
| req_busy | output | 1 | A request is in progress |
| bus_active | output | 1 | A bus cycle is being driven |
| bus_addr | output | 30 | Dword index of the current cycle |
| bus_be_n | output | 4 | Active-low lane enables |
| bus_write | output | 1 | Direction of the current cycle |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_rdata | input | 32 | Read data from the bus |
| bus_ready | input | 1 | Ends the current bus cycle |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Assembled read operand |

## Verification
The interesting overlap is that one request's completion and the next request's acceptance can fall in the same cycle. The bench raises `req_valid` with a fresh address in exactly the cycle where `done` is high.

It then judges two things:
- the finishing read's `done_rdata` against bytes computed from its own memory model;
- in the following cycle, that a bus cycle is active with the new dword index and enable pattern.

A second overlap covers the second cycle of a split read. There, the final lane gathering and the done pulse happen together. It is judged by comparing the assembled operand across dword-crossing reads, including one that wraps past the top address.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } phase_e;

endpackage

// File: rtl/splitter_lane_plan.sv
module splitter_lane_plan #(
    parameter int LANES = 4,
    localparam int LB   = $clog2(LANES)
) (
    input  logic [LB-1:0]    off,
    input  logic [1:0]       size,
    output logic [LB:0]      nbytes,
    output logic [LANES-1:0] en_lo,
    output logic [LANES-1:0] en_hi,
    output logic             split
);

    logic [2*LANES-1:0] span;

    always_comb begin
        int n;
        n = 1 << size;
        if (n > LANES) n = LANES;
        nbytes = n[LB:0];
    end

    for (genvar p = 0; p < 2*LANES; p++) begin : g_span
        assign span[p] = (p >= int'(off)) && (p < int'(off) + int'(nbytes));
    end

    assign en_lo = span[LANES-1:0];
    assign en_hi = span[2*LANES-1:LANES];
    assign split = |en_hi;

endmodule

// File: rtl/splitter_wr_steer.sv
module splitter_wr_steer #(
    parameter int LANES = 4,
    localparam int LB   = $clog2(LANES)
) (
    input  logic [8*LANES-1:0]  data,
    input  logic [LB-1:0]       off,
    input  logic [LB:0]         nbytes,
    output logic [16*LANES-1:0] lanes
);

    for (genvar p = 0; p < 2*LANES; p++) begin : g_lane
        logic [7:0] b;
        always_comb begin
            int k;
            k = p - int'(off);
            b = '0;
            for (int j = 0; j < LANES; j++) begin
                if (j == k && j < int'(nbytes)) b = data[8*j +: 8];
            end
        end
        assign lanes[8*p +: 8] = b;
    end

endmodule

// File: rtl/splitter_rd_gather.sv
module splitter_rd_gather #(
    parameter int LANES = 4,
    localparam int LB   = $clog2(LANES)
) (
    input  logic [16*LANES-1:0] window,
    input  logic [LB-1:0]       off,
    input  logic [LB:0]         nbytes,
    output logic [8*LANES-1:0]  operand
);

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        logic [7:0] b;
        always_comb begin
            b = '0;
            for (int p = 0; p < 2*LANES; p++) begin
                if (p == int'(off) + k && k < int'(nbytes)) b = window[8*p +: 8];
            end
        end
        assign operand[8*k +: 8] = b;
    end

endmodule

// File: rtl/xfer_lane_splitter.sv
module xfer_lane_splitter #(
    parameter int  AW    = 32,
    parameter int  DW    = 32,
    localparam int LANES = DW / 8,
    localparam int LB    = $clog2(LANES),
    localparam int DWA   = AW - LB
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [1:0]     req_size,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_busy,
    output logic           bus_active,
    output logic [DWA-1:0] bus_addr,
    output logic [LANES-1:0] bus_be_n,
    output logic           bus_write,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready,
    output logic           done,
    output logic [DW-1:0]  done_rdata
);
    import splitter_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [DWA-1:0]   addr;
        logic [LB-1:0]    off;
        logic [LB:0]      nbytes;
        logic             write;
        logic [LANES-1:0] en_lo;
        logic [LANES-1:0] en_hi;
        logic             split;
        logic [DW-1:0]    wr_lo;
        logic [DW-1:0]    wr_hi;
        logic [DW-1:0]    rbuf;
        logic             done;
        logic [DW-1:0]    done_data;
    } state_t;

    state_t s_d, s_q;

    logic [LB:0]      plan_n;
    logic [LANES-1:0] plan_lo, plan_hi;
    logic             plan_split;
    logic [2*DW-1:0]  steer;
    logic [2*DW-1:0]  window;
    logic [DW-1:0]    gathered;

    splitter_lane_plan #(.LANES(LANES)) u_plan (
        .off    (req_addr[LB-1:0]),
        .size   (req_size),
        .nbytes (plan_n),
        .en_lo  (plan_lo),
        .en_hi  (plan_hi),
        .split  (plan_split)
    );

    splitter_wr_steer #(.LANES(LANES)) u_steer (
        .data   (req_wdata),
        .off    (req_addr[LB-1:0]),
        .nbytes (plan_n),
        .lanes  (steer)
    );

    assign window = (s_q.phase == PH_HI) ? {bus_rdata, s_q.rbuf}
                                         : {{DW{1'b0}}, bus_rdata};

    splitter_rd_gather #(.LANES(LANES)) u_gather (
        .window  (window),
        .off     (s_q.off),
        .nbytes  (s_q.nbytes),
        .operand (gathered)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase  = PH_LO;
                    s_d.addr   = req_addr[AW-1:LB];
                    s_d.off    = req_addr[LB-1:0];
                    s_d.nbytes = plan_n;
                    s_d.write  = req_write;
                    s_d.en_lo  = plan_lo;
                    s_d.en_hi  = plan_hi;
                    s_d.split  = plan_split;
                    s_d.wr_lo  = steer[DW-1:0];
                    s_d.wr_hi  = steer[2*DW-1:DW];
                end
            end
            PH_LO: begin
                if (bus_ready) begin
                    s_d.rbuf = bus_rdata;
                    if (s_q.split) begin
                        s_d.phase = PH_HI;
                        s_d.addr  = s_q.addr + 1'b1;
                    end else begin
                        s_d.phase     = PH_IDLE;
                        s_d.done      = 1'b1;
                        s_d.done_data = s_q.write ? '0 : gathered;
                    end
                end
            end
            PH_HI: begin
                if (bus_ready) begin
                    s_d.phase     = PH_IDLE;
                    s_d.done      = 1'b1;
                    s_d.done_data = s_q.write ? '0 : gathered;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign req_busy   = (s_q.phase != PH_IDLE);
    assign bus_active = req_busy;
    assign bus_addr   = s_q.addr;
    assign bus_write  = bus_active & s_q.write;
    assign bus_be_n   = (s_q.phase == PH_LO) ? ~s_q.en_lo :
                        (s_q.phase == PH_HI) ? ~s_q.en_hi : '1;
    assign bus_wdata  = (s_q.phase == PH_LO) ? s_q.wr_lo :
                        (s_q.phase == PH_HI) ? s_q.wr_hi : '0;
    assign done       = s_q.done;
    assign done_rdata = s_q.done_data;

    logic [LANES:0] act_en;
    assign act_en = {1'b0, ~bus_be_n};

    // R4
    be_contig_chk: assert property (@(posedge clk) disable iff (rst)
        bus_active |-> (act_en != '0) && ((act_en & (act_en + (act_en & (~act_en + 1'b1)))) == '0));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_active && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_write)));

    // R5
    next_dword_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_LO && bus_ready && s_q.split) |=> (bus_active && bus_addr == $past(bus_addr) + 1'b1));

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_busy) |=> bus_active);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    idle_be_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_active |-> (bus_be_n == '1));

endmodule

// File: tb/tb_xfer_lane_splitter.sv
module tb_xfer_lane_splitter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_busy;
    logic        bus_active;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be_n;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ready = 1'b0;
    logic        done;
    logic [31:0] done_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    xfer_lane_splitter dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .req_busy(req_busy),
        .bus_active(bus_active), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .done(done), .done_rdata(done_rdata)
    );

    function automatic logic [7:0] fb(input logic [31:0] b);
        return b[7:0] ^ b[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] mem_word(input logic [29:0] dw);
        logic [31:0] w;
        for (int l = 0; l < 4; l++) w[8*l +: 8] = fb({dw, 2'(l)});
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a, input int n);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < n; k++) r[8*k +: 8] = fb(a + 32'(k));
        return r;
    endfunction

    assign bus_rdata = mem_word(bus_addr);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  dly;
        logic [1:0]  cyc;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 32'h0000_0100, 32'h0000_0000, 2'd0, 2'd1},
        '{1'b1, 2'd0, 32'h0000_0203, 32'h0000_00EF, 2'd1, 2'd1},
        '{1'b0, 2'd1, 32'h0000_0302, 32'h0000_0000, 2'd0, 2'd1},
        '{1'b1, 2'd1, 32'h0000_0403, 32'h0000_BEAD, 2'd0, 2'd2},
        '{1'b0, 2'd1, 32'h0000_0501, 32'h0000_0000, 2'd2, 2'd1},
        '{1'b0, 2'd2, 32'h0000_0600, 32'h0000_0000, 2'd0, 2'd1},
        '{1'b1, 2'd2, 32'h0000_0701, 32'h1234_5678, 2'd2, 2'd2},
        '{1'b0, 2'd2, 32'h0000_0802, 32'h0000_0000, 2'd0, 2'd2},
        '{1'b0, 2'd2, 32'h0000_0903, 32'h0000_0000, 2'd1, 2'd2},
        '{1'b1, 2'd2, 32'h0000_0A00, 32'hCAFE_F00D, 2'd0, 2'd1},
        '{1'b0, 2'd3, 32'h0000_0B02, 32'h0000_0000, 2'd0, 2'd2},
        '{1'b0, 2'd2, 32'hFFFF_FFFE, 32'h0000_0000, 2'd1, 2'd2},
        '{1'b1, 2'd1, 32'h0000_0C01, 32'h0000_A55A, 2'd0, 2'd1}
    };

    task automatic run_op(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, input int dly, input int exp_cyc);
        int n;
        int cycles;
        logic [3:0]  cov;
        logic [3:0]  want;
        logic [29:0] dw0;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        want = 4'((1 << n) - 1);
        dw0 = a[31:2];
        cov = '0;
        cycles = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_busy == 1'b1, "R9", 64'(req_busy), 64'd1);
        while (bus_active && cycles < 4) begin
            logic [29:0] sa;
            logic [3:0]  sbe;
            logic        swr;
            logic [4:0]  x;
            sa = bus_addr; sbe = bus_be_n; swr = bus_write;
            chk(bus_addr == dw0 + 30'(cycles), (cycles == 0) ? "R1" : "R5",
                64'(bus_addr), 64'(dw0 + 30'(cycles)));
            x = {1'b0, ~bus_be_n};
            chk(x != 0 && (x & (x + (x & (~x + 5'd1)))) == 0, "R4", 64'(bus_be_n), 64'(bus_be_n));
            chk(bus_write == wr, "R7", 64'(bus_write), 64'(wr));
            for (int l = 0; l < 4; l++) begin
                if (!bus_be_n[l]) begin
                    logic [31:0] k;
                    k = {bus_addr, 2'(l)} - a;
                    if (k < 32'(n)) begin
                        cov[k[1:0]] = 1'b1;
                        if (wr) chk(bus_wdata[8*l +: 8] == wd[8*k[1:0] +: 8], "R7",
                                    64'(bus_wdata[8*l +: 8]), 64'(wd[8*k[1:0] +: 8]));
                    end else begin
                        chk(1'b0, "R3", 64'(k), 64'(n));
                    end
                end
            end
            for (int w = 0; w < dly; w++) begin
                @(negedge clk);
                chk(bus_active && bus_addr == sa && bus_be_n == sbe && bus_write == swr, "R6",
                    {bus_addr, bus_be_n}, {sa, sbe});
            end
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
            cycles++;
        end
        chk(cycles == exp_cyc, "R5", 64'(cycles), 64'(exp_cyc));
        chk(cov == want, "R3", 64'(cov), 64'(want));
        chk(done == 1'b1 && req_busy == 1'b0, "R10", 64'({done, req_busy}), 64'b10);
        if (!wr) chk(done_rdata == exp_read(a, n), "R8", 64'(done_rdata), 64'(exp_read(a, n)));
        @(negedge clk);
        chk(!done && !bus_active, "R10", 64'({done, bus_active}), 64'd0);
    endtask

    bit finished = 0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(bus_be_n == 4'hF && !bus_active && !req_busy && !done, "R11",
            {bus_be_n, bus_active, req_busy, done}, 64'h78);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_be_n == 4'hF && !req_busy, "R11", 64'(bus_be_n), 64'hF);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++)
            run_op(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wdata, int'(VECS[i].dly), int'(VECS[i].cyc));

        // R9: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_1001; req_size = 2'd2;
        @(negedge clk);
        req_write = 1'b1; req_addr = 32'h0000_5000; req_size = 2'd0;
        @(negedge clk);
        chk(req_busy && bus_addr == 30'h400 && bus_be_n == 4'b0001 && !bus_write, "R9",
            {bus_addr, bus_be_n}, {30'h400, 4'b0001});
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0; req_valid = 1'b0;
        chk(bus_addr == 30'h401 && bus_be_n == 4'b1110, "R5", {bus_addr, bus_be_n}, {30'h401, 4'b1110});
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(done && done_rdata == exp_read(32'h1001, 4), "R8", 64'(done_rdata), 64'(exp_read(32'h1001, 4)));
        @(negedge clk);
        chk(!bus_active && !req_busy, "R9", 64'(bus_active), 64'd0);

        // R10: new request accepted in the done cycle
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_2002; req_size = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(done && done_rdata == exp_read(32'h2002, 2), "R10", 64'(done_rdata), 64'(exp_read(32'h2002, 2)));
        req_valid = 1'b1; req_addr = 32'h0000_3003; req_size = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_active && bus_addr == 30'hC00 && bus_be_n == 4'b0111, "R10",
            {bus_active, bus_addr, bus_be_n}, {1'b1, 30'hC00, 4'b0111});
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(done && done_rdata == exp_read(32'h3003, 1), "R8", 64'(done_rdata), 64'(exp_read(32'h3003, 1)));
        @(negedge clk);

        // R11: reset in the middle of a split write
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_4001; req_size = 2'd2; req_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_active, "R11", 64'(bus_active), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(bus_be_n == 4'hF && !bus_active && !req_busy && !done, "R11",
            {bus_be_n, bus_active, req_busy, done}, 64'h78);
        rst = 1'b0;
        @(negedge clk);
        chk(!bus_active && bus_be_n == 4'hF, "R11", 64'(bus_be_n), 64'hF);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule